// File: doc/BRIEF.md
# Zeroizing hash message register bank

This block is the register front end of a hash accelerator. Software fills a 512-bit message block through an AXI4-Lite slave port. The block is held as sixteen 32-bit words. Software then writes a start command. The bank drives the whole block in parallel to an external hash engine and gives it a one-cycle start pulse. The start pulse is only produced once every word has been written since the last clear and the engine is idle.

The plaintext words are held only as long as the engine needs them. The cycle the engine flags a finished digest, every message word is forced to zero. No later bus read, and no later engine transfer, can then expose the earlier message. The bank is also wiped by the chip-wide asynchronous reset and by a dedicated synchronous reset for this peripheral. A status register reports engine busy and a sticky digest-valid flag. Software polls these flags to sequence its work.

Top module: `hash_msg_wipe_bank`

## Requirements
- R1: While `rst_ni` is low, all message words are zero, `eng_start_o`, `bvalid_o` and `rvalid_o` are low, and the status register reads 0.
- R2: Word offsets 0x00 to 0x3C hold message words 0 to 15. A write updates only the byte lanes whose `wstrb_i` bit is set. A read returns the stored word with response OKAY (2'b00).
- R3: Write address and write data are accepted in either order or together. Each write produces exactly one response. `bvalid_o` and `bresp_o` hold until `bready_i`, and no new address or data is accepted while a response is pending.
- R4: A write to the control register (offset 0x40) with bit 0 set is a start command. It produces a single-cycle `eng_start_o` pulse in the cycle after the write completes, but only when the engine is idle and all sixteen words have been written since the last clear. Otherwise it is ignored.
- R5: The control register reads back as 0 with response OKAY.
- R6: While `eng_busy_i` is high, writes to message words leave them unchanged and still receive OKAY.
- R7: In the cycle after `eng_hash_valid_i` is high, every message word reads zero and `eng_block_o` is zero. The record of written words is also cleared, so a new start needs a full new message.
- R8: A message write that completes in the same cycle as `eng_hash_valid_i` is lost: the word is zero afterwards.
- R9: The status register (offset 0x44) reads bit 0 = `eng_busy_i` and bit 1 = digest valid. Digest valid is set by `eng_hash_valid_i` and stays set until the next accepted start.
- R10: Any word offset above 0x44 returns SLVERR (2'b10) on write and on read. Such reads return data 0, and such writes change nothing.
- R11: `eng_block_o[32*i+31:32*i]` always equals message word i.
- R12: A cycle with `periph_rst_i` high clears all message words, the written-word record, digest valid and any pending start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| periph_rst_i | input | 1 | Synchronous peripheral reset, active high |
| awaddr_i | input | 8 | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Write byte strobes |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | 8 | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| eng_block_o | output | 512 | Message block to the engine, word i at bits 32*i+31:32*i |
| eng_start_o | output | 1 | Single-cycle start pulse to the engine |
| eng_busy_i | input | 1 | Engine is computing |
| eng_hash_valid_i | input | 1 | Engine reports a finished digest |

## Verification
The checks assume the engine never reports a digest in the same cycle as it receives a start. They also assume the engine raises busy only after it has seen a start. The bench drives the engine inputs directly and keeps these two apart in time. The bus-side checks assume the master holds its address, data and ready signals stable between handshakes. The bench tasks change these signals only just after a clock edge and release a valid only after its handshake. The coincident write-and-wipe case is built by hand: the address phase completes first, then the data phase and the digest flag are raised together.

// File: rtl/hmb_pkg.sv
`timescale 1ns/1ps
package hmb_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam int CTRL_START_BIT = 0;
  localparam int STAT_BUSY_BIT  = 0;
  localparam int STAT_DV_BIT    = 1;

  typedef enum logic [1:0] {
    TGT_DATA,
    TGT_CTRL,
    TGT_STAT,
    TGT_NONE
  } tgt_e;
endpackage

// File: rtl/hmb_axil_wr.sv
`timescale 1ns/1ps
module hmb_axil_wr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic [STRB_W-1:0] req_strb_o,
  input  logic              req_err_i
);
  import hmb_pkg::*;

  logic              aw_held_q, w_held_q;
  logic [ADDR_W-1:0] aw_q;
  logic [DATA_W-1:0] wd_q;
  logic [STRB_W-1:0] ws_q;
  logic              aw_hs, w_hs;

  assign awready_o = ~aw_held_q & ~bvalid_o;
  assign wready_o  = ~w_held_q & ~bvalid_o;
  assign aw_hs     = awvalid_i & awready_o;
  assign w_hs      = wvalid_i & wready_o;

  // commit when both halves are present, held or arriving now
  assign req_o      = (aw_held_q | aw_hs) & (w_held_q | w_hs);
  assign req_addr_o = aw_held_q ? aw_q : awaddr_i;
  assign req_data_o = w_held_q ? wd_q : wdata_i;
  assign req_strb_o = w_held_q ? ws_q : wstrb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      aw_q      <= '0;
      wd_q      <= '0;
      ws_q      <= '0;
      bvalid_o  <= 1'b0;
      bresp_o   <= RESP_OKAY;
    end else if (req_o) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_o  <= 1'b1;
      bresp_o   <= req_err_i ? RESP_SLVERR : RESP_OKAY;
    end else begin
      if (aw_hs) begin
        aw_held_q <= 1'b1;
        aw_q      <= awaddr_i;
      end
      if (w_hs) begin
        w_held_q <= 1'b1;
        wd_q     <= wdata_i;
        ws_q     <= wstrb_i;
      end
      if (bvalid_o && bready_i) bvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hmb_axil_rd.sv
`timescale 1ns/1ps
module hmb_axil_rd #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_err_i
);
  import hmb_pkg::*;

  logic ar_hs;

  assign arready_o = ~rvalid_o;
  assign ar_hs     = arvalid_i & arready_o;
  assign rd_addr_o = araddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      rresp_o  <= RESP_OKAY;
    end else if (ar_hs) begin
      rvalid_o <= 1'b1;
      rdata_o  <= rd_err_i ? '0 : rd_data_i;
      rresp_o  <= rd_err_i ? RESP_SLVERR : RESP_OKAY;
    end else if (rvalid_o && rready_i) begin
      rvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hmb_msg_regs.sv
`timescale 1ns/1ps
module hmb_msg_regs #(
  parameter int N_WORDS = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(N_WORDS),
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      periph_rst_i,
  input  logic                      wipe_i,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [STRB_W-1:0]         wr_strb_i,
  input  logic                      busy_i,
  input  logic                      start_req_i,
  output logic                      start_o,
  output logic                      dv_o,
  output logic [N_WORDS*DATA_W-1:0] block_o
);
  logic [N_WORDS-1:0] filled_q;
  logic               clear;
  logic               start_acc;

  // wipe and peripheral reset win over any write in the same cycle
  assign clear = periph_rst_i | wipe_i;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q      <= '0;
        filled_q[g] <= 1'b0;
      end else if (clear) begin
        word_q      <= '0;
        filled_q[g] <= 1'b0;
      end else if (hit) begin
        filled_q[g] <= 1'b1;
        for (int b = 0; b < STRB_W; b++) begin
          if (wr_strb_i[b]) word_q[8*b +: 8] <= wr_data_i[8*b +: 8];
        end
      end
    end

    assign block_o[g*DATA_W +: DATA_W] = word_q;
  end

  assign start_acc = start_req_i & ~busy_i & (&filled_q) & ~clear;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      dv_o    <= 1'b0;
    end else if (periph_rst_i) begin
      start_o <= 1'b0;
      dv_o    <= 1'b0;
    end else begin
      start_o <= start_acc;
      if (wipe_i)         dv_o <= 1'b1;
      else if (start_acc) dv_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hash_msg_wipe_bank.sv
`timescale 1ns/1ps
module hash_msg_wipe_bank #(
  parameter int ADDR_W  = 8,
  parameter int N_WORDS = 16,
  parameter int DATA_W  = 32,
  localparam int STRB_W  = DATA_W / 8,
  localparam int BLOCK_W = N_WORDS * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               periph_rst_i,
  input  logic [ADDR_W-1:0]  awaddr_i,
  input  logic               awvalid_i,
  output logic               awready_o,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [STRB_W-1:0]  wstrb_i,
  input  logic               wvalid_i,
  output logic               wready_o,
  output logic [1:0]         bresp_o,
  output logic               bvalid_o,
  input  logic               bready_i,
  input  logic [ADDR_W-1:0]  araddr_i,
  input  logic               arvalid_i,
  output logic               arready_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [1:0]         rresp_o,
  output logic               rvalid_o,
  input  logic               rready_i,
  output logic [BLOCK_W-1:0] eng_block_o,
  output logic               eng_start_o,
  input  logic               eng_busy_i,
  input  logic               eng_hash_valid_i
);
  import hmb_pkg::*;

  localparam int WIDX_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(N_WORDS);

  function automatic tgt_e decode(input logic [WIDX_W-1:0] widx);
    if (widx < WIDX_W'(N_WORDS))         return TGT_DATA;
    else if (widx == WIDX_W'(N_WORDS))   return TGT_CTRL;
    else if (widx == WIDX_W'(N_WORDS+1)) return TGT_STAT;
    else                                 return TGT_NONE;
  endfunction

  logic              req;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic [STRB_W-1:0] req_strb;
  tgt_e              wr_tgt, rd_tgt;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_val;
  logic [IDX_W-1:0]  rd_idx;
  logic              data_wr, start_req, dv;
  logic [BLOCK_W-1:0] msg_block;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^{req_addr[1:0], rd_addr[1:0]};

  hmb_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr (
    .clk_i, .rst_ni,
    .awaddr_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wvalid_i, .wready_o,
    .bresp_o, .bvalid_o, .bready_i,
    .req_o      (req),
    .req_addr_o (req_addr),
    .req_data_o (req_data),
    .req_strb_o (req_strb),
    .req_err_i  (wr_tgt == TGT_NONE)
  );

  hmb_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd (
    .clk_i, .rst_ni,
    .araddr_i, .arvalid_i, .arready_o,
    .rdata_o, .rresp_o, .rvalid_o, .rready_i,
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_val),
    .rd_err_i  (rd_tgt == TGT_NONE)
  );

  assign wr_tgt    = decode(req_addr[ADDR_W-1:2]);
  assign data_wr   = req && (wr_tgt == TGT_DATA) && !eng_busy_i;
  assign start_req = req && (wr_tgt == TGT_CTRL) &&
                     req_strb[0] && req_data[CTRL_START_BIT];

  hmb_msg_regs #(.N_WORDS(N_WORDS), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni, .periph_rst_i,
    .wipe_i      (eng_hash_valid_i),
    .wr_en_i     (data_wr),
    .wr_idx_i    (req_addr[2 +: IDX_W]),
    .wr_data_i   (req_data),
    .wr_strb_i   (req_strb),
    .busy_i      (eng_busy_i),
    .start_req_i (start_req),
    .start_o     (eng_start_o),
    .dv_o        (dv),
    .block_o     (msg_block)
  );

  assign eng_block_o = msg_block;

  assign rd_tgt = decode(rd_addr[ADDR_W-1:2]);
  assign rd_idx = rd_addr[2 +: IDX_W];

  always_comb begin
    rd_val = '0;
    unique case (rd_tgt)
      TGT_DATA: rd_val = msg_block[rd_idx*DATA_W +: DATA_W];
      TGT_STAT: begin
        rd_val[STAT_BUSY_BIT] = eng_busy_i;
        rd_val[STAT_DV_BIT]   = dv;
      end
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/hmb_bank_checker.sv
`timescale 1ns/1ps
module hmb_bank_checker #(
  parameter int N_WORDS = 16,
  parameter int DATA_W  = 32,
  localparam int BLOCK_W = N_WORDS * DATA_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               periph_rst_i,
  input logic               awready_o,
  input logic               wready_o,
  input logic [1:0]         bresp_o,
  input logic               bvalid_o,
  input logic               bready_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [1:0]         rresp_o,
  input logic               rvalid_o,
  input logic               rready_i,
  input logic [BLOCK_W-1:0] eng_block_o,
  input logic               eng_start_o,
  input logic               eng_busy_i,
  input logic               eng_hash_valid_i
);
  a_r7_wipe_clears_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_hash_valid_i |=> (eng_block_o == '0));

  a_r12_periph_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_rst_i |=> (eng_block_o == '0) && !eng_start_o);

  a_r4_start_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  a_r4_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> $past(!eng_busy_i));

  a_r3_bresp_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_o && !bready_i) |=> bvalid_o && $stable(bresp_o));

  a_r3_no_accept_in_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o |-> (!awready_o && !wready_o));

  a_r2_rdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> rvalid_o && $stable(rdata_o) && $stable(rresp_o));

  a_r10_err_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && rresp_o == 2'b10) |-> (rdata_o == '0));
endmodule

bind hash_msg_wipe_bank hmb_bank_checker #(.N_WORDS(N_WORDS), .DATA_W(DATA_W)) i_hmb_chk (.*);

// File: tb/test_hash_msg_wipe_bank.sv
`timescale 1ns/1ps
module test_hash_msg_wipe_bank;
  localparam int NW = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         periph_rst_i = 1'b0;
  logic [7:0]   awaddr_i = '0;
  logic         awvalid_i = 1'b0;
  logic         awready_o;
  logic [31:0]  wdata_i = '0;
  logic [3:0]   wstrb_i = '0;
  logic         wvalid_i = 1'b0;
  logic         wready_o;
  logic [1:0]   bresp_o;
  logic         bvalid_o;
  logic         bready_i = 1'b1;
  logic [7:0]   araddr_i = '0;
  logic         arvalid_i = 1'b0;
  logic         arready_o;
  logic [31:0]  rdata_o;
  logic [1:0]   rresp_o;
  logic         rvalid_o;
  logic         rready_i = 1'b1;
  logic [511:0] eng_block_o;
  logic         eng_start_o;
  logic         eng_busy_i = 1'b0;
  logic         eng_hash_valid_i = 1'b0;

  hash_msg_wipe_bank i_hash_msg_wipe_bank (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  int n_starts = 0;
  bit done = 0;

  task automatic check(input string tag, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_data [NW];
  logic [15:0] m_fill;
  bit          m_dv, m_start, m_bvalid, m_rvalid;
  logic [1:0]  m_bresp, m_rresp;
  logic [31:0] m_rdata;
  int          aw_q [$];
  logic [31:0] wd_q [$];
  logic [3:0]  ws_q [$];

  always @(negedge clk_i) begin
    logic [511:0] m_blk;
    bit aw_hs, w_hs, ar_hs, commit;
    int idx, cidx;
    logic [31:0] cd;
    logic [3:0] cs;
    if (eng_start_o) n_starts++;
    if (rst_ni) begin
      for (int i = 0; i < NW; i++) m_blk[i*32 +: 32] = m_data[i];
      check("R11", "block", eng_block_o, m_blk);
      check("R4", "start", 512'(eng_start_o), 512'(m_start));
      check("R3", "awready", 512'(awready_o), 512'(aw_q.size() == 0 && !m_bvalid));
      check("R3", "wready", 512'(wready_o), 512'(wd_q.size() == 0 && !m_bvalid));
      check("R3", "bvalid", 512'(bvalid_o), 512'(m_bvalid));
      if (m_bvalid) check("R3", "bresp", 512'(bresp_o), 512'(m_bresp));
      check("R2", "arready", 512'(arready_o), 512'(!m_rvalid));
      check("R2", "rvalid", 512'(rvalid_o), 512'(m_rvalid));
      if (m_rvalid) begin
        check("R2", "rdata", 512'(rdata_o), 512'(m_rdata));
        check("R2", "rresp", 512'(rresp_o), 512'(m_rresp));
      end
    end
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) m_data[i] = '0;
      m_fill = '0; m_dv = 0; m_start = 0; m_bvalid = 0; m_rvalid = 0;
      m_bresp = 0; m_rresp = 0; m_rdata = 0;
      aw_q.delete(); wd_q.delete(); ws_q.delete();
    end else begin
      aw_hs = awvalid_i && aw_q.size() == 0 && !m_bvalid;
      w_hs  = wvalid_i && wd_q.size() == 0 && !m_bvalid;
      ar_hs = arvalid_i && !m_rvalid;
      if (ar_hs) begin
        idx = int'(araddr_i) >> 2;
        m_rresp = 2'b00;
        if (idx < NW) m_rdata = m_data[idx];
        else if (idx == NW) m_rdata = 0;
        else if (idx == NW + 1) m_rdata = {30'b0, m_dv, eng_busy_i};
        else begin m_rdata = 0; m_rresp = 2'b10; end
        m_rvalid = 1;
      end else if (m_rvalid && rready_i) m_rvalid = 0;
      if (aw_hs) aw_q.push_back(int'(awaddr_i));
      if (w_hs) begin wd_q.push_back(wdata_i); ws_q.push_back(wstrb_i); end
      commit = aw_q.size() > 0 && wd_q.size() > 0;
      cidx = 0; cd = 0; cs = 0;
      if (commit) begin
        cidx = aw_q.pop_front() >> 2;
        cd = wd_q.pop_front();
        cs = ws_q.pop_front();
        m_bvalid = 1;
        m_bresp = (cidx > NW + 1) ? 2'b10 : 2'b00;
      end else if (m_bvalid && bready_i) m_bvalid = 0;
      m_start = 0;
      if (periph_rst_i) begin
        for (int i = 0; i < NW; i++) m_data[i] = '0;
        m_fill = '0; m_dv = 0;
      end else if (eng_hash_valid_i) begin
        for (int i = 0; i < NW; i++) m_data[i] = '0;
        m_fill = '0; m_dv = 1;
      end else if (commit) begin
        if (cidx < NW && !eng_busy_i) begin
          for (int b = 0; b < 4; b++)
            if (cs[b]) m_data[cidx][8*b +: 8] = cd[8*b +: 8];
          m_fill[cidx] = 1'b1;
        end else if (cidx == NW && cs[0] && cd[0] && !eng_busy_i && m_fill == 16'hFFFF) begin
          m_start = 1;
          m_dv = 0;
        end
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic cycles(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int order, output logic [1:0] resp);
    bit aw_done = 0, w_done = 0, aw_now, w_now;
    @(posedge clk_i); #1;
    if (order != 2) begin awaddr_i = a; awvalid_i = 1; end
    if (order != 1) begin wdata_i = d; wstrb_i = s; wvalid_i = 1; end
    while (!(aw_done && w_done)) begin
      @(negedge clk_i);
      aw_now = awvalid_i && awready_o;
      w_now  = wvalid_i && wready_o;
      @(posedge clk_i); #1;
      if (aw_now) begin awvalid_i = 0; aw_done = 1; end
      if (w_now) begin wvalid_i = 0; w_done = 1; end
      if (aw_done && !w_done && !wvalid_i) begin wdata_i = d; wstrb_i = s; wvalid_i = 1; end
      if (w_done && !aw_done && !awvalid_i) begin awaddr_i = a; awvalid_i = 1; end
    end
    @(negedge clk_i);
    while (!bvalid_o) @(negedge clk_i);
    resp = bresp_o;
    if (bready_i) begin @(posedge clk_i); #1; end
  endtask

  task automatic axi_read(input logic [7:0] a, output logic [31:0] d, output logic [1:0] resp);
    bit hs;
    @(posedge clk_i); #1;
    araddr_i = a; arvalid_i = 1;
    hs = 0;
    while (!hs) begin
      @(negedge clk_i);
      hs = arready_o;
      @(posedge clk_i); #1;
    end
    arvalid_i = 0;
    @(negedge clk_i);
    while (!rvalid_o) @(negedge clk_i);
    d = rdata_o; resp = rresp_o;
    @(posedge clk_i); #1;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE0000 | (i * 32'h111) | 32'h1;
  endfunction

  task automatic fill_all(input int base);
    logic [1:0] r;
    for (int i = 0; i < NW; i++) axi_write(8'(i * 4), pat(i + base), 4'hF, i % 3, r);
  endtask

  initial begin
    repeat (40000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] r;
    logic [31:0] d;
    int st;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check("R1", "bvalid in reset", 512'(bvalid_o), 0);
    check("R1", "rvalid in reset", 512'(rvalid_o), 0);
    check("R1", "start in reset", 512'(eng_start_o), 0);
    check("R1", "block in reset", eng_block_o, 0);
    rst_ni = 1;
    cycles(2);
    axi_read(8'h44, d, r);
    check("R1", "status after reset", 512'(d), 0);
    axi_read(8'h00, d, r);
    check("R1", "word0 after reset", 512'(d), 0);

    // R4: start with incomplete message is ignored
    axi_write(8'h00, 32'h1234, 4'hF, 0, r);
    axi_write(8'h40, 32'h1, 4'hF, 0, r);
    cycles(3);
    check("R4", "no start on partial message", n_starts, 0);

    // R2/R3: full message, three handshake orders
    fill_all(0);
    axi_read(8'h0C, d, r);
    check("R2", "word3 readback", 512'(d), 512'(pat(3)));
    check("R2", "word3 resp", 512'(r), 0);
    @(negedge clk_i);
    check("R11", "block word5", 512'(eng_block_o[5*32 +: 32]), 512'(pat(5)));
    axi_write(8'h08, 32'hFFFFFFFF, 4'b0101, 1, r);
    axi_read(8'h08, d, r);
    check("R2", "byte strobes", 512'(d), 512'((pat(2) & 32'hFF00FF00) | 32'h00FF00FF));

    // R5, R10
    axi_read(8'h40, d, r);
    check("R5", "ctrl reads zero", 512'(d), 0);
    check("R5", "ctrl resp", 512'(r), 0);
    axi_write(8'h48, 32'hFFFF, 4'hF, 2, r);
    check("R10", "undefined write resp", 512'(r), 512'(2'b10));
    axi_read(8'h48, d, r);
    check("R10", "undefined read resp", 512'(r), 512'(2'b10));
    check("R10", "undefined read data", 512'(d), 0);
    axi_read(8'hFC, d, r);
    check("R10", "top read resp", 512'(r), 512'(2'b10));

    // R4: start bit clear does nothing, then a real start
    axi_write(8'h40, 32'h0, 4'hF, 0, r);
    cycles(2);
    check("R4", "ctrl bit0 clear no start", n_starts, 0);
    axi_write(8'h40, 32'h1, 4'hF, 0, r);
    cycles(2);
    check("R4", "accepted start", n_starts, 1);

    // R6, R9: busy engine
    eng_busy_i = 1;
    axi_write(8'h00, 32'hDEAD, 4'hF, 0, r);
    check("R6", "busy write resp", 512'(r), 0);
    axi_read(8'h00, d, r);
    check("R6", "busy write discarded", 512'(d), 512'(pat(0)));
    axi_write(8'h40, 32'h1, 4'hF, 1, r);
    cycles(2);
    check("R4", "start ignored while busy", n_starts, 1);
    axi_read(8'h44, d, r);
    check("R9", "status busy bit", 512'(d), 1);

    // R8: write completing with hash valid is lost
    @(posedge clk_i); #1;
    awaddr_i = 8'h1C; awvalid_i = 1;
    @(posedge clk_i); #1;
    awvalid_i = 0;
    wdata_i = 32'h7777; wstrb_i = 4'hF; wvalid_i = 1;
    eng_busy_i = 0; eng_hash_valid_i = 1;
    @(posedge clk_i); #1;
    wvalid_i = 0; eng_hash_valid_i = 0;
    @(negedge clk_i);
    check("R8", "coincident write resp", 512'(bvalid_o ? bresp_o : 2'b11), 0);
    check("R7", "block wiped", eng_block_o, 0);
    axi_read(8'h1C, d, r);
    check("R8", "coincident write lost", 512'(d), 0);
    axi_read(8'h00, d, r);
    check("R7", "word0 wiped", 512'(d), 0);
    axi_read(8'h44, d, r);
    check("R9", "digest valid set", 512'(d), 2);
    axi_write(8'h40, 32'h1, 4'hF, 0, r);
    cycles(2);
    check("R7", "no start after wipe until refill", n_starts, 1);

    // R9: dv held until next accepted start
    fill_all(7);
    axi_read(8'h44, d, r);
    check("R9", "digest valid held", 512'(d), 2);
    axi_write(8'h40, 32'h1, 4'hF, 2, r);
    cycles(2);
    check("R4", "second start", n_starts, 2);
    axi_read(8'h44, d, r);
    check("R9", "digest valid cleared by start", 512'(d), 0);

    // R12: peripheral reset
    axi_write(8'h10, 32'h4444, 4'hF, 0, r);
    @(posedge clk_i); #1; periph_rst_i = 1;
    @(posedge clk_i); #1; periph_rst_i = 0;
    axi_read(8'h10, d, r);
    check("R12", "word4 cleared", 512'(d), 0);
    check("R12", "block cleared", eng_block_o, 0);
    st = n_starts;
    axi_write(8'h40, 32'h1, 4'hF, 0, r);
    cycles(2);
    check("R12", "record cleared so no start", n_starts, st);

    // R3: response held under back-pressure
    bready_i = 0;
    axi_write(8'h04, 32'hABCD, 4'hF, 1, r);
    cycles(3);
    @(negedge clk_i);
    check("R3", "bvalid held", 512'(bvalid_o), 1);
    check("R3", "no aw accept while resp pending", 512'(awready_o), 0);
    @(posedge clk_i); #1; bready_i = 1;
    cycles(1);
    check("R3", "bvalid released", 512'(bvalid_o), 0);
    axi_read(8'h04, d, r);
    check("R3", "stalled write landed once", 512'(d), 512'(32'hABCD));

    cycles(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule